// File: doc/BRIEF.md
# Generational Reschedule Supervisor

This block runs one process instance on one processor through a life cycle that schedules its own successor. When started with a process name and an instance number, it broadcasts a check so that any duplicate of the same generation can respond. It then informs its grandparent that it is alive and waits one scheduling interval. Next it asks the network to start its successor and opens the work phase. Once the work is done it listens for its grandchild's notice for one more interval. If that notice does not come, it schedules the grandchild itself.

Recovery is part of normal operation and has no separate error path. Each instance has a priority equal to its instance number plus the processor id, reduced modulo the processor count. When two copies of one generation exist, the lower-priority copy asks to be killed. It stops only when a valid reply arrives from a higher-priority copy of its own instance. In strict mode an instance also stops when neither its father nor its grandfather answers its check. While it lives, the instance answers checks from its descendants and kill requests under its own name. Instance numbers wrap modulo the processor count.

Top module: `gen_supervisor`

## Requirements
- R1: After `start`, the first message sent is a check (type 0) carrying the configured name, the own instance number and the own priority. A grandparent notice (type 2, own instance) is sent only after that check.
- R2: The priority is (instance + processor id) mod NPROC. The successor number is instance+1 mod NPROC, the grandchild number is instance+2 mod NPROC, and the ancestor numbers are instance-1 and instance-2 mod NPROC. All of them wrap.
- R3: When the check window of `cfg_interval` ticks closes without a duplicate, the block sends the notice. After a further `cfg_interval` ticks it sends a schedule request (type 3) for instance+1 with its own priority. It then holds `work_en` high until `work_done`.
- R4: A notice (type 2) under the own name for instance+2 may be received at any time during the life. This includes the cycle in which `work_done` is asserted. If it is received, the life ends with code 0 and no grandchild schedule request is sent.
- R5: If no such notice arrives within `cfg_interval` ticks after `work_done`, the block sends a schedule request (type 3) for instance+2 and ends with code 1. Notices with another name or another instance number are ignored.
- R6: Every waiting window counts `tick` pulses only. Cycles without `tick` do not advance a window.
- R7: A check (type 0) may arrive during the check window with the own name, the own instance and a higher priority. In that case the block sends a kill request (type 4) that carries the name, instance 0 and priority 0. A check of this kind with a lower priority, or with another name, has no effect.
- R8: While a kill request is pending, the block ends with code 2 only on a kill reply (type 5) with the own name, the own instance and a priority higher than its own. Any other reply is ignored.
- R9: With `strict` set, the block continues only if an acknowledge (type 1) under the own name from instance-1 or instance-2 arrives during the check window. Otherwise it ends with code 3 and sends nothing after the check.
- R10: While alive, the block answers a check from instance+1 or instance+2 under its own name with an acknowledge (type 1), and a kill request under its own name with a kill reply (type 5). Both answers carry the own instance and priority and are sent in cycles where the block has no message of its own to send.
- R11: After reset `tx_valid`, `work_en` and `done` are low. Each life ends with `done` high for exactly one cycle, with `done_code` valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a life with the configuration inputs (sampled while idle) |
| cfg_name | input | NAME_W | Process name |
| cfg_inst | input | SLOT_W | Instance number, below NPROC |
| proc_id | input | SLOT_W | Physical processor id, below NPROC |
| strict | input | 1 | Require an ancestor acknowledge to continue |
| cfg_interval | input | CNT_W | Scheduling interval in ticks |
| tick | input | 1 | Timer tick |
| work_done | input | 1 | Work phase finished |
| rx_valid | input | 1 | Received message valid |
| rx_type | input | 3 | Received message type |
| rx_name | input | NAME_W | Received process name |
| rx_inst | input | SLOT_W | Received instance number |
| rx_pri | input | SLOT_W | Received priority |
| tx_valid | output | 1 | Message to send valid |
| tx_type | output | 3 | Sent message type |
| tx_name | output | NAME_W | Sent process name |
| tx_inst | output | SLOT_W | Sent instance number |
| tx_pri | output | SLOT_W | Sent priority |
| work_en | output | 1 | Work phase may run |
| done | output | 1 | One-cycle end-of-life pulse |
| done_code | output | 2 | 0 notice seen, 1 grandchild rescheduled, 2 killed, 3 no ancestor |

## Verification
The grandchild's notice can arrive in the same cycle in which the work phase reports completion. The block must take both events in that one cycle and end at once without a grandchild schedule request. The bench provokes this by driving `work_done` and the matching notice on the same clock edge. It judges the outcome by a done code of 0 and by the absence of any further message in the scoreboard. A second overlap is a reply to a descendant that falls due while the supervisor has its own message to send. The order in the scoreboard expects the supervisor's message first and the reply after it.

// File: rtl/gen_sup_pkg.sv
package gen_sup_pkg;

  typedef enum logic [2:0] {
    MSG_CHECK = 3'd0,
    MSG_ACK   = 3'd1,
    MSG_NOTE  = 3'd2,
    MSG_SCHED = 3'd3,
    MSG_KREQ  = 3'd4,
    MSG_KREP  = 3'd5
  } msg_e;

  typedef enum logic [1:0] {
    END_NORMAL  = 2'd0,
    END_RESCHED = 2'd1,
    END_KILLED  = 2'd2,
    END_ORPHAN  = 2'd3
  } end_e;

  typedef enum logic [3:0] {
    S_IDLE, S_CHK_TX, S_CHK_WAIT, S_KREQ_TX, S_KWAIT, S_NOTE_TX,
    S_IV_WAIT, S_SCH_TX, S_WORK, S_GC_WAIT, S_GC_TX, S_EXIT
  } st_e;

endpackage

// File: rtl/gen_sup_ring.sv
module gen_sup_ring #(
  parameter int NPROC  = 8,
  parameter int SLOT_W = $clog2(NPROC)
) (
  input  logic [SLOT_W-1:0] inst,
  input  logic [SLOT_W-1:0] pid,
  output logic [SLOT_W-1:0] pri,
  output logic [SLOT_W-1:0] inst_p1,
  output logic [SLOT_W-1:0] inst_p2,
  output logic [SLOT_W-1:0] inst_m1,
  output logic [SLOT_W-1:0] inst_m2
);
  localparam logic [SLOT_W:0]   NP   = (SLOT_W+1)'(NPROC);
  localparam logic [SLOT_W-1:0] ONE  = SLOT_W'(1);
  localparam logic [SLOT_W-1:0] TWO  = SLOT_W'(2);
  localparam logic [SLOT_W-1:0] BK1  = SLOT_W'(NPROC - 1);
  localparam logic [SLOT_W-1:0] BK2  = SLOT_W'(NPROC - 2);

  // both operands below NPROC: one conditional subtract is enough
  function automatic logic [SLOT_W-1:0] add_mod(input logic [SLOT_W-1:0] a,
                                                input logic [SLOT_W-1:0] b);
    logic [SLOT_W:0] s;
    s = {1'b0, a} + {1'b0, b};
    if (s >= NP) s = s - NP;
    return s[SLOT_W-1:0];
  endfunction

  always_comb begin
    pri     = add_mod(inst, pid);
    inst_p1 = add_mod(inst, ONE);
    inst_p2 = add_mod(inst, TWO);
    inst_m1 = add_mod(inst, BK1);
    inst_m2 = add_mod(inst, BK2);
  end
endmodule

// File: rtl/gen_sup_timer.sv
module gen_sup_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             tick,
  input  logic [CNT_W-1:0] cfg,
  output logic             expired
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)                    cnt <= '0;
    else if (load)              cnt <= cfg;
    else if (tick && cnt != '0) cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);

  // R6: no tick, no progress
  p_hold_without_tick_r6: assert property (@(posedge clk) disable iff (rst)
    (!load && !tick) |=> $stable(cnt));
endmodule

// File: rtl/gen_sup_resp.sv
module gen_sup_resp
  import gen_sup_pkg::*;
#(
  parameter int NAME_W = 8,
  parameter int SLOT_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              active,
  input  logic [NAME_W-1:0] my_name,
  input  logic [SLOT_W-1:0] my_inst,
  input  logic [SLOT_W-1:0] my_pri,
  input  logic [SLOT_W-1:0] inst_p1,
  input  logic [SLOT_W-1:0] inst_p2,
  input  logic [SLOT_W-1:0] inst_m1,
  input  logic [SLOT_W-1:0] inst_m2,
  input  logic              rx_valid,
  input  msg_e              rx_type,
  input  logic [NAME_W-1:0] rx_name,
  input  logic [SLOT_W-1:0] rx_inst,
  input  logic [SLOT_W-1:0] rx_pri,
  input  logic              grant,
  output logic              req_valid,
  output msg_e              req_type,
  output logic              dup_any,
  output logic              anc_any,
  output logic              gc_any,
  output logic              kill_ok
);
  logic name_ok, hit_dup, hit_desc, hit_anc, hit_gc, hit_kreq;
  logic dup_q, anc_q, gc_q, pend_ack, pend_krep;

  always_comb begin
    name_ok  = active && rx_valid && (rx_name == my_name);
    hit_dup  = name_ok && rx_type == MSG_CHECK && rx_inst == my_inst && rx_pri > my_pri;
    hit_desc = name_ok && rx_type == MSG_CHECK && (rx_inst == inst_p1 || rx_inst == inst_p2);
    hit_anc  = name_ok && rx_type == MSG_ACK && (rx_inst == inst_m1 || rx_inst == inst_m2);
    hit_gc   = name_ok && rx_type == MSG_NOTE && rx_inst == inst_p2;
    hit_kreq = name_ok && rx_type == MSG_KREQ;
    kill_ok  = name_ok && rx_type == MSG_KREP && rx_inst == my_inst && rx_pri > my_pri;
  end

  always_ff @(posedge clk) begin
    if (rst || !active) begin
      dup_q     <= 1'b0;
      anc_q     <= 1'b0;
      gc_q      <= 1'b0;
      pend_ack  <= 1'b0;
      pend_krep <= 1'b0;
    end else begin
      if (hit_dup) dup_q <= 1'b1;
      if (hit_anc) anc_q <= 1'b1;
      if (hit_gc)  gc_q  <= 1'b1;
      if (hit_desc)                  pend_ack <= 1'b1;
      else if (grant && pend_ack)    pend_ack <= 1'b0;
      if (hit_kreq)                              pend_krep <= 1'b1;
      else if (grant && !pend_ack && pend_krep)  pend_krep <= 1'b0;
    end
  end

  assign dup_any   = dup_q | hit_dup;
  assign anc_any   = anc_q | hit_anc;
  assign gc_any    = gc_q  | hit_gc;
  assign req_valid = pend_ack | pend_krep;
  assign req_type  = pend_ack ? MSG_ACK : MSG_KREP;

  // R10: an answer waiting for the bus is held until it is granted
  p_reply_held_r10: assert property (@(posedge clk) disable iff (rst)
    (active && pend_ack && !grant) |=> pend_ack);
endmodule

// File: rtl/gen_supervisor.sv
module gen_supervisor
  import gen_sup_pkg::*;
#(
  parameter int NAME_W = 8,
  parameter int NPROC  = 8,
  parameter int SLOT_W = $clog2(NPROC),
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [NAME_W-1:0] cfg_name,
  input  logic [SLOT_W-1:0] cfg_inst,
  input  logic [SLOT_W-1:0] proc_id,
  input  logic              strict,
  input  logic [CNT_W-1:0]  cfg_interval,
  input  logic              tick,
  input  logic              work_done,
  input  logic              rx_valid,
  input  logic [2:0]        rx_type,
  input  logic [NAME_W-1:0] rx_name,
  input  logic [SLOT_W-1:0] rx_inst,
  input  logic [SLOT_W-1:0] rx_pri,
  output logic              tx_valid,
  output logic [2:0]        tx_type,
  output logic [NAME_W-1:0] tx_name,
  output logic [SLOT_W-1:0] tx_inst,
  output logic [SLOT_W-1:0] tx_pri,
  output logic              work_en,
  output logic              done,
  output logic [1:0]        done_code
);
  st_e  state, state_d;
  end_e end_q, end_d;

  logic [NAME_W-1:0] name_q;
  logic [SLOT_W-1:0] inst_q, pid_q;
  logic              strict_q;
  logic [CNT_W-1:0]  ivl_q;
  logic              sent_check;

  logic [SLOT_W-1:0] pri, inst_p1, inst_p2, inst_m1, inst_m2;
  logic              active, fsm_tx, tmr_load, expired;
  logic              req_valid, dup_any, anc_any, gc_any, kill_ok;
  msg_e              req_type;

  gen_sup_ring #(.NPROC(NPROC), .SLOT_W(SLOT_W)) u_ring (
    .inst(inst_q), .pid(pid_q), .pri(pri),
    .inst_p1(inst_p1), .inst_p2(inst_p2), .inst_m1(inst_m1), .inst_m2(inst_m2)
  );

  gen_sup_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst(rst), .load(tmr_load), .tick(tick), .cfg(ivl_q), .expired(expired)
  );

  gen_sup_resp #(.NAME_W(NAME_W), .SLOT_W(SLOT_W)) u_resp (
    .clk(clk), .rst(rst), .active(active),
    .my_name(name_q), .my_inst(inst_q), .my_pri(pri),
    .inst_p1(inst_p1), .inst_p2(inst_p2), .inst_m1(inst_m1), .inst_m2(inst_m2),
    .rx_valid(rx_valid), .rx_type(msg_e'(rx_type)), .rx_name(rx_name),
    .rx_inst(rx_inst), .rx_pri(rx_pri), .grant(!fsm_tx),
    .req_valid(req_valid), .req_type(req_type),
    .dup_any(dup_any), .anc_any(anc_any), .gc_any(gc_any), .kill_ok(kill_ok)
  );

  assign active = (state != S_IDLE);
  assign fsm_tx = (state == S_CHK_TX) || (state == S_KREQ_TX) || (state == S_NOTE_TX) ||
                  (state == S_SCH_TX) || (state == S_GC_TX);

  always_comb begin
    state_d = state;
    end_d   = end_q;
    unique case (state)
      S_IDLE:     if (start) state_d = S_CHK_TX;
      S_CHK_TX:   state_d = S_CHK_WAIT;
      S_CHK_WAIT: if (expired) begin
                    if (dup_any)                   state_d = S_KREQ_TX;
                    else if (strict_q && !anc_any) begin state_d = S_EXIT; end_d = END_ORPHAN; end
                    else                           state_d = S_NOTE_TX;
                  end
      S_KREQ_TX:  state_d = S_KWAIT;
      S_KWAIT:    if (kill_ok) begin state_d = S_EXIT; end_d = END_KILLED; end
                  else if (expired) begin
                    if (strict_q && !anc_any) begin state_d = S_EXIT; end_d = END_ORPHAN; end
                    else                           state_d = S_NOTE_TX;
                  end
      S_NOTE_TX:  state_d = S_IV_WAIT;
      S_IV_WAIT:  if (expired) state_d = S_SCH_TX;
      S_SCH_TX:   state_d = S_WORK;
      S_WORK:     if (work_done) begin
                    if (gc_any) begin state_d = S_EXIT; end_d = END_NORMAL; end
                    else        state_d = S_GC_WAIT;
                  end
      S_GC_WAIT:  if (gc_any) begin state_d = S_EXIT; end_d = END_NORMAL; end
                  else if (expired) state_d = S_GC_TX;
      S_GC_TX:    begin state_d = S_EXIT; end_d = END_RESCHED; end
      S_EXIT:     state_d = S_IDLE;
      default:    state_d = S_IDLE;
    endcase
  end

  assign tmr_load = (state_d != state) &&
                    (state_d == S_CHK_WAIT || state_d == S_KWAIT ||
                     state_d == S_IV_WAIT  || state_d == S_GC_WAIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_IDLE;
      end_q      <= END_NORMAL;
      name_q     <= '0;
      inst_q     <= '0;
      pid_q      <= '0;
      strict_q   <= 1'b0;
      ivl_q      <= '0;
      sent_check <= 1'b0;
      work_en    <= 1'b0;
      done       <= 1'b0;
      done_code  <= 2'd0;
    end else begin
      state   <= state_d;
      end_q   <= end_d;
      work_en <= (state_d == S_WORK);
      done    <= (state == S_EXIT);
      if (state == S_EXIT) done_code <= end_q;
      if (state == S_IDLE && start) begin
        name_q   <= cfg_name;
        inst_q   <= cfg_inst;
        pid_q    <= proc_id;
        strict_q <= strict;
        ivl_q    <= cfg_interval;
      end
      if (state == S_IDLE)        sent_check <= 1'b0;
      else if (state == S_CHK_TX) sent_check <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_valid <= 1'b0;
      tx_type  <= 3'd0;
      tx_name  <= '0;
      tx_inst  <= '0;
      tx_pri   <= '0;
    end else begin
      tx_valid <= 1'b0;
      if (fsm_tx) begin
        tx_valid <= 1'b1;
        tx_name  <= name_q;
        tx_pri   <= pri;
        unique case (state)
          S_CHK_TX:  begin tx_type <= MSG_CHECK; tx_inst <= inst_q; end
          S_KREQ_TX: begin tx_type <= MSG_KREQ;  tx_inst <= '0; tx_pri <= '0; end
          S_NOTE_TX: begin tx_type <= MSG_NOTE;  tx_inst <= inst_q; end
          S_SCH_TX:  begin tx_type <= MSG_SCHED; tx_inst <= inst_p1; end
          default:   begin tx_type <= MSG_SCHED; tx_inst <= inst_p2; end
        endcase
      end else if (req_valid) begin
        tx_valid <= 1'b1;
        tx_type  <= req_type;
        tx_name  <= name_q;
        tx_inst  <= inst_q;
        tx_pri   <= pri;
      end
    end
  end

  // R1: the grandparent notice never precedes the duplicate check
  p_check_before_note_r1: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && tx_type == MSG_NOTE) |-> sent_check);

  // R2: priority stays inside the processor range
  p_pri_range_r2: assert property (@(posedge clk) disable iff (rst)
    active |-> ({1'b0, pri} < (SLOT_W+1)'(NPROC)));

  // R4: a seen grandchild notice forbids the direct reschedule
  p_no_resched_after_gc_r4: assert property (@(posedge clk) disable iff (rst)
    (state == S_GC_TX) |-> !u_resp.gc_any);

  // R10: answers only go out during a life
  p_reply_in_life_r10: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && (tx_type == MSG_ACK || tx_type == MSG_KREP)) |-> sent_check);

  // R11: end pulse lasts one cycle and never overlaps the work phase
  p_done_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  p_done_no_work_r11: assert property (@(posedge clk) disable iff (rst)
    done |-> !work_en);
endmodule

// File: tb/tb_gen_supervisor.sv
module tb_gen_supervisor;
  localparam int NAME_W = 8;
  localparam int NPROC  = 8;
  localparam int SLOT_W = 3;
  localparam int CNT_W  = 16;
  localparam int L      = 6;
  localparam logic [7:0] NM = 8'h5A;
  // own inst 6, proc 5 -> pri 3; +1=7, +2=0, -1=5, -2=4

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 0, strict = 0, tick = 1, work_done = 0, rx_valid = 0;
  logic [NAME_W-1:0] cfg_name = NM, rx_name = 0;
  logic [SLOT_W-1:0] cfg_inst = 3'd6, proc_id = 3'd5, rx_inst = 0, rx_pri = 0;
  logic [CNT_W-1:0]  cfg_interval = CNT_W'(L);
  logic [2:0]        rx_type = 0;
  logic              tx_valid, work_en, done;
  logic [2:0]        tx_type;
  logic [NAME_W-1:0] tx_name;
  logic [SLOT_W-1:0] tx_inst, tx_pri;
  logic [1:0]        done_code;

  always #2.5 clk = ~clk;

  gen_supervisor #(.NAME_W(NAME_W), .NPROC(NPROC), .SLOT_W(SLOT_W), .CNT_W(CNT_W)) dut (
    .clk(clk), .rst(rst), .start(start), .cfg_name(cfg_name), .cfg_inst(cfg_inst),
    .proc_id(proc_id), .strict(strict), .cfg_interval(cfg_interval), .tick(tick),
    .work_done(work_done), .rx_valid(rx_valid), .rx_type(rx_type), .rx_name(rx_name),
    .rx_inst(rx_inst), .rx_pri(rx_pri), .tx_valid(tx_valid), .tx_type(tx_type),
    .tx_name(tx_name), .tx_inst(tx_inst), .tx_pri(tx_pri), .work_en(work_en),
    .done(done), .done_code(done_code)
  );

  typedef struct {
    logic [2:0] t; logic [7:0] n; logic [2:0] i; logic [2:0] p; string tag;
  } item_t;
  item_t exp_q[$];

  int total = 0, bad = 0;
  int n_tx = 0, done_cnt = 0, cyc = 0, tx_cyc = 0;
  logic [1:0] last_code = 0;

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic push(input logic [2:0] t, input logic [2:0] i, input logic [2:0] p,
                      input string tag);
    item_t it;
    it.t = t; it.n = NM; it.i = i; it.p = p; it.tag = tag;
    exp_q.push_back(it);
  endtask

  // monitor: pop expected messages as they appear
  always @(negedge clk) begin
    cyc++;
    if (!rst && tx_valid) begin
      n_tx++;
      tx_cyc = cyc;
      if (exp_q.size() == 0) begin
        check(0, "R10 unexpected message type", int'(tx_type), -1);
      end else begin
        item_t e;
        e = exp_q.pop_front();
        check(tx_type == e.t, {e.tag, " type"}, int'(tx_type), int'(e.t));
        check(tx_name == e.n, {e.tag, " name"}, int'(tx_name), int'(e.n));
        check(tx_inst == e.i, {e.tag, " inst"}, int'(tx_inst), int'(e.i));
        check(tx_pri  == e.p, {e.tag, " pri"},  int'(tx_pri),  int'(e.p));
      end
    end
    if (!rst && done) begin
      done_cnt++;
      last_code = done_code;
    end
  end

  task automatic send_rx(input logic [2:0] t, input logic [7:0] n,
                         input logic [2:0] i, input logic [2:0] p);
    @(negedge clk);
    rx_valid = 1; rx_type = t; rx_name = n; rx_inst = i; rx_pri = p;
    @(negedge clk);
    rx_valid = 0;
  endtask

  task automatic begin_life(input logic s);
    push(3'd0, 3'd6, 3'd3, "R1 R2 check");
    @(negedge clk);
    strict = s; start = 1;
    @(negedge clk);
    start = 0;
  endtask

  task automatic end_life(input int base, input int code, input string tag);
    wait (done_cnt == base + 1);
    check(int'(last_code) == code, tag, int'(last_code), code);
    repeat (10) @(negedge clk);
    check(exp_q.size() == 0, {tag, " all messages sent"}, exp_q.size(), 0);
  endtask

  task automatic pulse_done();
    @(negedge clk); work_done = 1;
    @(negedge clk); work_done = 0;
  endtask

  initial begin
    int base, k, t0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check(tx_valid == 0, "R11 reset tx_valid", tx_valid, 0);
    check(work_en == 0,  "R11 reset work_en", work_en, 0);
    check(done == 0,     "R11 reset done", done, 0);

    // life A: lower-pri dup and foreign name ignored, grandchild notice in window
    base = done_cnt; k = n_tx;
    begin_life(0);
    wait (n_tx == k + 1);
    send_rx(3'd0, NM, 3'd6, 3'd1);      // R7 lower priority duplicate
    send_rx(3'd0, 8'h33, 3'd6, 3'd7);   // R7 other name
    push(3'd2, 3'd6, 3'd3, "R3 notice");
    push(3'd3, 3'd7, 3'd3, "R3 successor schedule");
    wait (work_en);
    repeat (4) @(negedge clk);
    check(work_en == 1, "R3 work_en held", work_en, 1);
    pulse_done();
    repeat (2) @(negedge clk);
    send_rx(3'd2, NM, 3'd0, 3'd2);
    end_life(base, 0, "R4 notice in window");

    // life B: timeout with tick gating, ignored notices
    base = done_cnt; k = n_tx;
    begin_life(0);
    push(3'd2, 3'd6, 3'd3, "R3 notice");
    push(3'd3, 3'd7, 3'd3, "R3 successor schedule");
    wait (work_en);
    @(negedge clk);
    tick = 0;
    pulse_done();
    k = n_tx;
    send_rx(3'd2, 8'h33, 3'd0, 3'd1);   // R5 foreign name
    send_rx(3'd2, NM, 3'd7, 3'd1);      // R5 child, not grandchild
    repeat (16) @(negedge clk);
    check(n_tx == k, "R6 window frozen without tick", n_tx - k, 0);
    push(3'd3, 3'd0, 3'd3, "R5 grandchild schedule");
    tick = 1; t0 = cyc;
    wait (done_cnt == base + 1);
    check((tx_cyc - t0) >= L && (tx_cyc - t0) <= L + 4, "R6 timeout length",
          tx_cyc - t0, L + 2);
    end_life(base, 1, "R5 direct reschedule");

    // life C: strict, only a descendant acknowledges
    base = done_cnt; k = n_tx;
    begin_life(1);
    wait (n_tx == k + 1);
    send_rx(3'd1, NM, 3'd7, 3'd0);
    end_life(base, 3, "R9 strict without ancestor");
    check(n_tx == k + 1, "R9 only the check was sent", n_tx - k, 1);

    // life D: strict with grandfather ack, answers, simultaneous notice and done
    base = done_cnt; k = n_tx;
    begin_life(1);
    wait (n_tx == k + 1);
    send_rx(3'd1, NM, 3'd4, 3'd0);
    push(3'd2, 3'd6, 3'd3, "R9 notice after ancestor ack");
    push(3'd3, 3'd7, 3'd3, "R3 successor schedule");
    wait (work_en);
    push(3'd1, 3'd6, 3'd3, "R10 ack to child");
    send_rx(3'd0, NM, 3'd7, 3'd2);
    send_rx(3'd0, 8'h33, 3'd7, 3'd2);   // R10 other name ignored
    repeat (3) @(negedge clk);
    push(3'd5, 3'd6, 3'd3, "R10 kill reply");
    send_rx(3'd4, NM, 3'd0, 3'd0);
    repeat (3) @(negedge clk);
    check(work_en == 1, "R10 still working", work_en, 1);
    @(negedge clk);
    work_done = 1; rx_valid = 1; rx_type = 3'd2; rx_name = NM; rx_inst = 3'd0; rx_pri = 3'd2;
    @(negedge clk);
    work_done = 0; rx_valid = 0;
    end_life(base, 0, "R4 notice with work_done");

    // life E: higher duplicate, invalid replies ignored, valid reply kills
    base = done_cnt; k = n_tx;
    begin_life(0);
    wait (n_tx == k + 1);
    push(3'd4, 3'd0, 3'd0, "R7 kill request");
    send_rx(3'd0, NM, 3'd6, 3'd7);
    wait (n_tx == k + 2);
    send_rx(3'd5, NM, 3'd5, 3'd7);      // R8 wrong instance
    send_rx(3'd5, NM, 3'd6, 3'd2);      // R8 lower priority
    check(done_cnt == base, "R8 invalid replies ignored", done_cnt - base, 0);
    send_rx(3'd5, NM, 3'd6, 3'd7);
    end_life(base, 2, "R8 killed by valid reply");
    @(negedge clk);
    check(done == 0, "R11 done pulse ended", done, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule